// File: doc/BRIEF.md
# Self-Test Phase Sequencer

This block runs a built-in self-test of a programmable array as a fixed series of phases. During each phase it steps through every configuration row of the half of the array under test. For each row it steps through every frame that reconfigures the blocks under test. It issues one frame-write request per (phase, row, frame) step and hands the actual frame write to a neighbouring agent through a request/acknowledge handshake. Once every row and frame of a phase has been written, it pulses a test-start strobe and waits for the test to report completion. It then records that phase's pass/fail outcome and moves on to the next phase.

Software drives the block through two memory-mapped registers. The control register (address 0) is write-only. It selects the session region, loads the phase, row and frame counts, and launches a run. The done flag that the sequencer latches into it is brought out on a port. The status register (address 1) is read-only. It returns one fail bit per phase, a sticky fail flag, a busy flag and a copy of the done flag.

Top module: `bist_phase_sequencer`

## Requirements
- R1: A synchronous active-high reset, applied at any time, returns the sequencer to idle. It clears the frame request, the test-start strobe, the done flag and every status bit.
- R2: A write to address 0 while idle loads the configuration. The fields are: bit 0 = run, bits [2:1] = region, bits [5:3] = phases minus one, bits [9:6] = rows minus one, bits [13:10] = frames minus one. A run starts only if bit 0 is 1, and the frame request rises in the cycle after the write.
- R3: Frame requests follow the order frame (innermost), then row, then phase (outermost). Phase, row and frame indices count from 0, and the region output equals the loaded region field.
- R4: A frame request stays high with unchanged indices until acknowledged. Each cycle with request and acknowledge both high completes exactly one frame.
- R5: The cycle after the acknowledge of a phase's last frame of its last row, test-start is high for exactly one cycle. No frame request is made from then until that phase's test completes.
- R6: Test completion may arrive any number of cycles after test-start. On completion, status bit p (p = phase index, bits [7:0]) is set when the pass input is low. Status bit 8 is a sticky OR of all fail bits.
- R7: On completion of the last phase, the done flag (port and status bit 10) is set and the sequencer returns to idle. Status bit 9 (busy) is high exactly while a run is in progress.
- R8: Writes to address 0 during a run are ignored. The run keeps its original counts and region.
- R9: Starting a new run clears the done flag and all fail bits.
- R10: Reads of address 1 return the status register. Reads of any other address return zero, including the write-only control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data |
| frm_req | output | 1 | Frame-write request |
| frm_ack | input | 1 | Frame-write acknowledge |
| frm_region | output | 2 | Session region of the request |
| frm_phase | output | PH_W | Phase index of the request |
| frm_row | output | ROW_W | Row index of the request |
| frm_frame | output | FRM_W | Frame index of the request |
| test_start | output | 1 | One-cycle test execution strobe |
| test_done | input | 1 | Test completion |
| test_pass | input | 1 | Test outcome, valid with test_done |
| busy | output | 1 | Run in progress |
| seq_done | output | 1 | Done flag of the control register |

## Verification
The hardest behaviour to reach is a control write that lands mid-run while a frame request is being held. That write has to be issued after the request rises but before it is acknowledged. The bench therefore issues the write from inside its acknowledge loop, on the first frame of a run, with the acknowledge held back. It then checks that every later index and the final phase count still match the original configuration. Phase-wrap paths are reached with vectors that combine single-row, single-frame and multi-row, multi-frame shapes with varied acknowledge and completion delays. A reset issued in the middle of a frame walk is also covered.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_t;

    // Event handed from the state machine to the register bank
    typedef struct packed {
        logic rec;   // a phase completed this cycle
        logic fail;  // its outcome was a failure
        logic fin;   // it was the last phase
    } seq_evt_t;

    localparam int REG_CTRL        = 0;
    localparam int REG_STAT        = 1;
    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_REGION_LSB = 1;
    localparam int CTRL_PHASE_LSB  = 3;

    function automatic int ctrl_row_lsb(input int ph_w);
        return CTRL_PHASE_LSB + ph_w;
    endfunction

    function automatic int ctrl_frm_lsb(input int ph_w, input int row_w);
        return CTRL_PHASE_LSB + ph_w + row_w;
    endfunction

endpackage

// File: rtl/bseq_counter.sv
module bseq_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + W'(1);
    end

    assign at_last = (cnt == last);
endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       frm_ack,
    input  logic       test_done,
    input  logic       test_pass,
    input  logic       frame_last,
    input  logic       row_last,
    input  logic       phase_last,
    output seq_state_t state,
    output logic       frame_clr,
    output logic       frame_inc,
    output logic       row_clr,
    output logic       row_inc,
    output logic       phase_inc,
    output seq_evt_t   evt
);
    seq_state_t nxt;
    logic       step, row_end, phase_end;

    assign step      = (state == ST_WRITE) && frm_ack;
    assign row_end   = step && frame_last;
    assign phase_end = row_end && row_last;

    assign frame_clr = start || row_end;
    assign frame_inc = step && !frame_last;
    assign row_clr   = start || phase_end;
    assign row_inc   = row_end && !row_last;

    always_comb begin
        evt.rec   = (state == ST_WAIT) && test_done;
        evt.fail  = !test_pass;
        evt.fin   = evt.rec && phase_last;
        phase_inc = evt.rec && !phase_last;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_WRITE;
            ST_WRITE: if (phase_end) nxt = ST_EXEC;
            ST_EXEC:  nxt = ST_WAIT;
            ST_WAIT:  if (test_done) nxt = phase_last ? ST_IDLE : ST_WRITE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/bseq_regs.sv
module bseq_regs
    import bseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int PH_W   = 3,
    parameter int ROW_W  = 4,
    parameter int FRM_W  = 4,
    localparam int NPH   = 1 << PH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              idle,
    input  seq_evt_t          evt,
    input  logic [PH_W-1:0]   evt_phase,
    output logic              start,
    output logic [1:0]        region,
    output logic [PH_W-1:0]   phase_last,
    output logic [ROW_W-1:0]  row_last,
    output logic [FRM_W-1:0]  frm_last,
    output logic              done
);
    localparam int ROW_LSB = ctrl_row_lsb(PH_W);
    localparam int FRM_LSB = ctrl_frm_lsb(PH_W, ROW_W);

    logic           ctrl_wr;
    logic [NPH-1:0] fail_q;
    logic           sticky_q;
    logic           unused_wbits;

    assign ctrl_wr      = bus_we && (bus_addr == ADDR_W'(REG_CTRL)) && idle;
    assign start        = ctrl_wr && bus_wdata[CTRL_RUN_BIT];
    assign unused_wbits = ^bus_wdata;

    // Write-only control register: configuration fields plus the done flag
    always_ff @(posedge clk) begin
        if (rst) begin
            region     <= '0;
            phase_last <= '0;
            row_last   <= '0;
            frm_last   <= '0;
            done       <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                region     <= bus_wdata[CTRL_REGION_LSB +: 2];
                phase_last <= bus_wdata[CTRL_PHASE_LSB +: PH_W];
                row_last   <= bus_wdata[ROW_LSB +: ROW_W];
                frm_last   <= bus_wdata[FRM_LSB +: FRM_W];
            end
            if (start)        done <= 1'b0;
            else if (evt.fin) done <= 1'b1;
        end
    end

    // Result register: one fail bit per phase plus a sticky flag
    always_ff @(posedge clk) begin
        if (rst || start) begin
            fail_q   <= '0;
            sticky_q <= 1'b0;
        end else if (evt.rec && evt.fail) begin
            fail_q[evt_phase] <= 1'b1;
            sticky_q          <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_STAT)) begin
            bus_rdata[NPH-1:0] = fail_q;
            bus_rdata[NPH]     = sticky_q;
            bus_rdata[NPH+1]   = !idle;
            bus_rdata[NPH+2]   = done;
        end
    end
endmodule

// File: rtl/bist_phase_sequencer.sv
module bist_phase_sequencer
    import bseq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int PH_W   = 3,
    parameter int ROW_W  = 4,
    parameter int FRM_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              frm_req,
    input  logic              frm_ack,
    output logic [1:0]        frm_region,
    output logic [PH_W-1:0]   frm_phase,
    output logic [ROW_W-1:0]  frm_row,
    output logic [FRM_W-1:0]  frm_frame,
    output logic              test_start,
    input  logic              test_done,
    input  logic              test_pass,
    output logic              busy,
    output logic              seq_done
);
    seq_state_t       state;
    seq_evt_t         evt;
    logic             start;
    logic [PH_W-1:0]  phase_lim;
    logic [ROW_W-1:0] row_lim;
    logic [FRM_W-1:0] frm_lim;
    logic             frame_clr, frame_inc, row_clr, row_inc, phase_inc;
    logic             frame_last, row_last, phase_last;

    bseq_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .PH_W(PH_W), .ROW_W(ROW_W), .FRM_W(FRM_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .idle(state == ST_IDLE), .evt(evt), .evt_phase(frm_phase),
        .start(start), .region(frm_region),
        .phase_last(phase_lim), .row_last(row_lim), .frm_last(frm_lim),
        .done(seq_done)
    );

    bseq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .frm_ack(frm_ack), .test_done(test_done), .test_pass(test_pass),
        .frame_last(frame_last), .row_last(row_last), .phase_last(phase_last),
        .state(state),
        .frame_clr(frame_clr), .frame_inc(frame_inc),
        .row_clr(row_clr), .row_inc(row_inc),
        .phase_inc(phase_inc), .evt(evt)
    );

    bseq_counter #(.W(FRM_W)) u_frame_cnt (
        .clk(clk), .rst(rst), .clr(frame_clr), .inc(frame_inc),
        .last(frm_lim), .cnt(frm_frame), .at_last(frame_last)
    );

    bseq_counter #(.W(ROW_W)) u_row_cnt (
        .clk(clk), .rst(rst), .clr(row_clr), .inc(row_inc),
        .last(row_lim), .cnt(frm_row), .at_last(row_last)
    );

    bseq_counter #(.W(PH_W)) u_phase_cnt (
        .clk(clk), .rst(rst), .clr(start), .inc(phase_inc),
        .last(phase_lim), .cnt(frm_phase), .at_last(phase_last)
    );

    assign frm_req    = (state == ST_WRITE);
    assign test_start = (state == ST_EXEC);
    assign busy       = (state != ST_IDLE);
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int PH_W  = 3,
    parameter int ROW_W = 4,
    parameter int FRM_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_req,
    input logic             frm_ack,
    input logic [PH_W-1:0]  frm_phase,
    input logic [ROW_W-1:0] frm_row,
    input logic [FRM_W-1:0] frm_frame,
    input logic             test_start,
    input logic             busy,
    input logic             seq_done
);
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        (frm_req && !frm_ack) |=> frm_req);

    a_r4_idx_stable: assert property (@(posedge clk) disable iff (rst)
        (frm_req && !frm_ack) |=> $stable({frm_phase, frm_row, frm_frame}));

    a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
        test_start |=> !test_start);

    a_r5_start_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(test_start) |-> $past(frm_req && frm_ack));

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> !busy);
endmodule

bind bist_phase_sequencer bseq_checker #(
    .PH_W(PH_W), .ROW_W(ROW_W), .FRM_W(FRM_W)
) u_bseq_checker (
    .clk(clk), .rst(rst),
    .frm_req(frm_req), .frm_ack(frm_ack),
    .frm_phase(frm_phase), .frm_row(frm_row), .frm_frame(frm_frame),
    .test_start(test_start), .busy(busy), .seq_done(seq_done)
);

// File: tb/tb_bist_phase_sequencer.sv
module tb_bist_phase_sequencer;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int PH_W   = 3;
    localparam int ROW_W  = 4;
    localparam int FRM_W  = 4;

    // Vector: phases[25:22] rows[21:18] frames[17:14] region[13:12] failmask[11:4] delay[3:0]
    localparam int NVEC = 5;
    localparam logic [25:0] VEC [NVEC] = '{
        {4'd1, 4'd1, 4'd1, 2'd0, 8'h00, 4'd0},
        {4'd6, 4'd2, 4'd3, 2'd1, 8'h24, 4'd1},
        {4'd3, 4'd3, 4'd2, 2'd2, 8'h00, 4'd2},
        {4'd2, 4'd1, 4'd4, 2'd3, 8'h03, 4'd0},
        {4'd8, 4'd1, 4'd1, 2'd0, 8'h81, 4'd3}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              frm_req, frm_ack;
    logic [1:0]        frm_region;
    logic [PH_W-1:0]   frm_phase;
    logic [ROW_W-1:0]  frm_row;
    logic [FRM_W-1:0]  frm_frame;
    logic              test_start, test_done, test_pass, busy, seq_done;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    bist_phase_sequencer #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .PH_W(PH_W), .ROW_W(ROW_W), .FRM_W(FRM_W)
    ) dut (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .frm_req(frm_req), .frm_ack(frm_ack), .frm_region(frm_region),
        .frm_phase(frm_phase), .frm_row(frm_row), .frm_frame(frm_frame),
        .test_start(test_start), .test_done(test_done), .test_pass(test_pass),
        .busy(busy), .seq_done(seq_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int ph, input int rw,
                                              input int fr, input int rg,
                                              input bit run);
        return 32'(run) | 32'(rg << 1) | 32'((ph - 1) << 3)
             | 32'((rw - 1) << 6) | 32'((fr - 1) << 10);
    endfunction

    task automatic bus_write(input logic [31:0] data);
        bus_we    = 1'b1;
        bus_addr  = 2'd0;
        bus_wdata = data;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 2'd1;
    endtask

    task automatic read_reg(input int addr, output int val);
        bus_addr = ADDR_W'(addr);
        #1;
        val = int'(bus_rdata);
        bus_addr = 2'd1;
    endtask

    task automatic run_case(input int ph, input int rw, input int fr, input int rg,
                            input logic [7:0] fmask, input int dly, input bit poke);
        int st;
        int expst;
        bus_write(ctrl_word(ph, rw, fr, rg, 1'b1));
        read_reg(1, st);
        chk("R9 status cleared at start (busy only)", st, 1 << 9);
        chk("R9 done cleared at start", int'(seq_done), 0);
        for (int p = 0; p < ph; p++) begin
            for (int r = 0; r < rw; r++) begin
                for (int f = 0; f < fr; f++) begin
                    chk("R2 request raised", int'(frm_req), 1);
                    chk("R3 phase index", int'(frm_phase), p);
                    chk("R3 row index", int'(frm_row), r);
                    chk("R3 frame index", int'(frm_frame), f);
                    chk("R3 region", int'(frm_region), rg);
                    if (poke && p == 0 && r == 0 && f == 0) begin
                        bus_write(ctrl_word(8, 2, 2, (rg + 1) % 4, 1'b1));
                        chk("R8 request kept after busy write", int'(frm_req), 1);
                        chk("R8 region kept after busy write", int'(frm_region), rg);
                    end
                    for (int d = 0; d < dly; d++) begin
                        @(negedge clk);
                        chk("R4 request held", int'(frm_req), 1);
                        chk("R4 frame index stable", int'(frm_frame), f);
                    end
                    frm_ack = 1'b1;
                    @(negedge clk);
                    frm_ack = 1'b0;
                end
            end
            chk("R5 test start after last ack", int'(test_start), 1);
            chk("R5 no request at test start", int'(frm_req), 0);
            @(negedge clk);
            chk("R5 test start one cycle", int'(test_start), 0);
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                chk("R6 waiting no request", int'(frm_req), 0);
                chk("R6 waiting no restart", int'(test_start), 0);
            end
            test_done = 1'b1;
            test_pass = !fmask[p];
            @(negedge clk);
            test_done = 1'b0;
            test_pass = 1'b0;
        end
        chk("R7 done flag", int'(seq_done), 1);
        chk("R7 idle after last phase", int'(busy), 0);
        chk("R7 no request after last phase", int'(frm_req), 0);
        expst = int'(fmask & 8'((1 << ph) - 1));
        if (expst != 0) expst |= (1 << 8);
        expst |= (1 << 10);
        read_reg(1, st);
        chk("R6 status fail bits and sticky", st, expst);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int v;
        rst       = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = 2'd1;
        bus_wdata = '0;
        frm_ack   = 1'b0;
        test_done = 1'b0;
        test_pass = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 request low after reset", int'(frm_req), 0);
        chk("R1 test start low after reset", int'(test_start), 0);
        chk("R1 done low after reset", int'(seq_done), 0);
        read_reg(1, v);
        chk("R1 status zero after reset", v, 0);

        // R2: configuration write without the run bit does not start
        bus_write(ctrl_word(2, 2, 2, 1, 1'b0));
        @(negedge clk);
        chk("R2 no run without run bit", int'(frm_req), 0);
        chk("R2 still idle", int'(busy), 0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            run_case(int'(VEC[i][25:22]), int'(VEC[i][21:18]), int'(VEC[i][17:14]),
                     int'(VEC[i][13:12]), VEC[i][11:4], int'(VEC[i][3:0]), i == 1);
            repeat (2) @(negedge clk);
        end

        // R10: write-only control register reads as zero
        read_reg(0, v);
        chk("R10 control address reads zero", v, 0);
        read_reg(2, v);
        chk("R10 unmapped address reads zero", v, 0);

        // Full session shape: six phases, longest completion delay
        run_case(6, 2, 2, 2, 8'h20, 9, 1'b0);

        // R1: reset after a failing run clears done and results
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 done cleared by reset", int'(seq_done), 0);
        read_reg(1, v);
        chk("R1 results cleared by reset", v, 0);

        // R1: reset in the middle of a frame walk
        bus_write(ctrl_word(2, 2, 2, 3, 1'b1));
        frm_ack = 1'b1;
        @(negedge clk);
        frm_ack = 1'b0;
        chk("R4 second frame after one ack", int'(frm_frame), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 request dropped by mid-run reset", int'(frm_req), 0);
        chk("R1 idle after mid-run reset", int'(busy), 0);
        @(negedge clk);
        chk("R1 no test start after mid-run reset", int'(test_start), 0);

        // Run again after reset to show the sequencer restarts cleanly
        run_case(1, 2, 1, 1, 8'h01, 0, 1'b0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule